// File: doc/BRIEF.md
# 64B/66B Transmit Block Encoder

This block sits on the transmit side of a 64B/66B physical coding layer, ahead of the scrambler. Each clock it takes eight byte lanes and a per-lane control flag. From them it forms one 66-bit block whose two-bit sync header marks the block as data or as control. A block of pure data passes through behind a data header. A block that holds any control byte becomes a control block: an 8-bit type byte followed by a payload that mixes 8-bit data bytes and 7-bit control codes.

The type byte depends on the block's shape: an all-control block, a start in the lowest lane, or a terminate in any of the eight lanes. The encoder picks the type from the positions of the start and terminate characters. It then moves each remaining byte to its field in the control block layout. Any mix of lanes that fits none of these shapes produces a block filled with error codes. The output is registered, so it appears one clock after the inputs.

Lane i occupies input bits [8i+7:8i]. Its control flag is bit i of the flag vector. The control characters are recognised by value: idle 0x07, error 0xFE, start 0xFB and terminate 0xFD.

Top module: `tx66_enc`

## Requirements
- R1: When no control flag is set, the block has header value 2'b01 in bits [1:0], and lane i appears unchanged at bits [8i+9:8i+2].
- R2: When all flags are set and every lane holds idle (0x07) or error (0xFE), the header is 2'b10 and the type 0x1E is in bits [9:2]. Lane j's 7-bit code is in bits [7j+16:7j+10], where idle maps to 0x00 and error maps to 0x1E.
- R3: A flag vector of 0x01 with the start character 0xFB in lane 0 gives header 2'b10 and type 0x78. Lanes 1 to 7 then appear unchanged, with lane j at bits [8j+9:8j+2].
- R4: A terminate (0xFD) in lane k, with data in all lanes below k and idle or error in all lanes above k, gives header 2'b10. The type is 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 or 0xFF for k = 0 to 7. Data lane j<k sits at bits [8j+17:8j+10], and the code for lane j>k sits at bits [7j+16:7j+10].
- R5: In a terminate block, every payload bit that is not the type, a data byte or a code is zero. For example, bits [16:10] are zero when k = 0.
- R6: Any other lane pattern gives header 2'b10, type 0x1E and all eight code fields equal to 0x1E. This covers a start outside lane 0, data after a terminate, unknown control characters, and control flags that are not contiguous.
- R7: The block for a given input appears on the output after exactly one rising clock edge and holds steady between edges.
- R8: While rst_n is low at a rising edge, the output becomes the all-idle control block: header 2'b10, type 0x1E and all codes 0x00, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_bytes | input | 64 | Eight byte lanes, lane 0 in the low bits |
| tx_is_ctrl | input | 8 | Per-lane control flag |
| tx_block | output | 66 | Encoded block, sync header in bits [1:0] |

## Verification
The hardest shapes to reach are the terminate blocks at the edges, lane 0 and lane 7. Here the layout degenerates: a terminate in lane 0 has no data, and a terminate in lane 7 has no codes. The zero padding between the data bytes and the codes has a different width for every lane. The stimulus table walks the terminate through all eight lanes with known byte values and compares each result bit for bit. It then adds rejected shapes that lie one step away from a legal one: a control byte that is not a code after a terminate, a start in the wrong lane, and a gap in the flag vector.

// File: rtl/tx66_pkg.sv
// Shared constants for the 64B/66B transmit encoder.
// Assumes eight byte lanes per block; the terminate type bytes are defined
// for that lane count only.
package tx66_pkg;

    localparam logic [7:0] CH_IDLE   = 8'h07;
    localparam logic [7:0] CH_ERROR  = 8'hFE;
    localparam logic [7:0] CH_START  = 8'hFB;
    localparam logic [7:0] CH_TERM   = 8'hFD;

    localparam logic [6:0] CODE_IDLE  = 7'h00;
    localparam logic [6:0] CODE_ERROR = 7'h1E;

    localparam logic [7:0] TY_CTRL  = 8'h1E;
    localparam logic [7:0] TY_START = 8'h78;

    localparam logic [1:0] HDR_DATA = 2'b01;
    localparam logic [1:0] HDR_CTRL = 2'b10;

    // Type byte of a terminate block, by the lane holding the terminate.
    function automatic logic [7:0] term_type(input int unsigned pos);
        case (pos)
            0:       term_type = 8'h87;
            1:       term_type = 8'h99;
            2:       term_type = 8'hAA;
            3:       term_type = 8'hB4;
            4:       term_type = 8'hCC;
            5:       term_type = 8'hD2;
            6:       term_type = 8'hE1;
            default: term_type = 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/tx66_lane_map.sv
// Per-lane classifier: flags each byte as idle/error code, start or
// terminate character, and gives its 7-bit code.
// Assumes the lane's control flag is qualified elsewhere.
module tx66_lane_map
    import tx66_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic [8*LANES-1:0] lane_data,
    output logic [LANES-1:0]   code_ok,
    output logic [LANES-1:0]   is_start,
    output logic [LANES-1:0]   is_term,
    output logic [7*LANES-1:0] code7
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] b;
        assign b = lane_data[8*g +: 8];
        // byte is a control value that has a 7-bit code
        assign code_ok[g]         = (b == CH_IDLE) || (b == CH_ERROR);
        // 7-bit code; only meaningful when code_ok is set
        assign code7[7*g +: 7]    = (b == CH_ERROR) ? CODE_ERROR : CODE_IDLE;
        // start and terminate markers
        assign is_start[g]        = (b == CH_START);
        assign is_term[g]         = (b == CH_TERM);
    end

endmodule

// File: rtl/tx66_pack.sv
// Block former: picks the block shape from the control flags and lane
// classes, selects the type byte and places data bytes and 7-bit codes.
// Data lane j of a terminate block sits at payload bit 8+8j and the code of
// lane j at payload bit 8+7j; unused bits stay zero. Assumes LANES = 8.
module tx66_pack
    import tx66_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic [8*LANES-1:0] data,
    input  logic [LANES-1:0]   ctrl,
    input  logic [LANES-1:0]   code_ok,
    input  logic [LANES-1:0]   is_start,
    input  logic [LANES-1:0]   is_term,
    input  logic [7*LANES-1:0] code7,
    output logic [8*LANES+1:0] blk_next,
    output logic [LANES-1:0]   term_hit
);

    localparam int PW = 8 * LANES;
    localparam logic [LANES-1:0] ALL_CTRL  = '1;
    localparam logic [LANES-1:0] LANE0_CTL = LANES'(1);

    logic [PW-1:0] payload;
    logic [1:0]    hdr;

    // Find which terminate position, if any, the lane pattern matches.
    always_comb begin
        logic above_ok;
        term_hit = '0;
        for (int k = 0; k < LANES; k++) begin
            above_ok = 1'b1;
            for (int j = 0; j < LANES; j++) begin
                if (j > k) above_ok = above_ok & code_ok[j];
            end
            term_hit[k] = (ctrl == (ALL_CTRL << k)) && is_term[k] && above_ok;
        end
    end

    // Build header and payload for the detected block shape.
    always_comb begin
        payload = '0;
        hdr     = HDR_CTRL;
        if (ctrl == '0) begin
            hdr     = HDR_DATA;
            payload = data;
        end else if (ctrl == LANE0_CTL && is_start[0]) begin
            payload = {data[PW-1:8], TY_START};
        end else if (|term_hit) begin
            for (int k = 0; k < LANES; k++) begin
                if (term_hit[k]) begin
                    payload[7:0] = term_type(k);
                    for (int j = 0; j < LANES; j++) begin
                        if (j < k)      payload[8+8*j +: 8] = data[8*j +: 8];
                        else if (j > k) payload[8+7*j +: 7] = code7[7*j +: 7];
                    end
                end
            end
        end else if (&ctrl && &code_ok) begin
            payload[7:0] = TY_CTRL;
            for (int j = 0; j < LANES; j++) payload[8+7*j +: 7] = code7[7*j +: 7];
        end else begin
            payload[7:0] = TY_CTRL;
            for (int j = 0; j < LANES; j++) payload[8+7*j +: 7] = CODE_ERROR;
        end
        blk_next = {payload, hdr};
    end

endmodule

// File: rtl/tx66_enc.sv
// 64B/66B transmit block encoder top: classifies lanes, forms the block
// and registers it. One clock of latency; sync header in bits [1:0].
// Assumes synchronous active-low reset and LANES = 8.
module tx66_enc
    import tx66_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [8*LANES-1:0] tx_bytes,
    input  logic [LANES-1:0]   tx_is_ctrl,
    output logic [8*LANES+1:0] tx_block
);

    localparam int PW = 8 * LANES;
    localparam logic [PW+1:0]    IDLE_BLOCK = {{(PW-8){1'b0}}, TY_CTRL, HDR_CTRL};
    localparam logic [LANES-1:0] LANE0_CTL  = LANES'(1);

    logic [LANES-1:0]   code_ok, is_start, is_term, term_hit;
    logic [7*LANES-1:0] code7;
    logic [PW+1:0]      blk_next;

    tx66_lane_map #(.LANES(LANES)) lane_map_i (
        .lane_data (tx_bytes),
        .code_ok   (code_ok),
        .is_start  (is_start),
        .is_term   (is_term),
        .code7     (code7)
    );

    tx66_pack #(.LANES(LANES)) pack_i (
        .data      (tx_bytes),
        .ctrl      (tx_is_ctrl),
        .code_ok   (code_ok),
        .is_start  (is_start),
        .is_term   (is_term),
        .code7     (code7),
        .blk_next  (blk_next),
        .term_hit  (term_hit)
    );

    // Output register: idle block in reset, formed block otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_block <= IDLE_BLOCK;
        else        tx_block <= blk_next;
    end

    // R1: pure data input yields a data header and unchanged lanes
    p_data_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tx_is_ctrl) == '0) |->
            (tx_block[1:0] == HDR_DATA && tx_block[PW+1:2] == $past(tx_bytes)));

    // R2: any control flag yields a control header
    p_ctrl_hdr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tx_is_ctrl) != '0) |-> (tx_block[1:0] == HDR_CTRL));

    // R3: a start type only follows a lane-0 start character
    p_start_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && tx_block[1:0] == HDR_CTRL && tx_block[9:2] == TY_START) |->
            ($past(tx_is_ctrl) == LANE0_CTL && $past(tx_bytes[7:0]) == CH_START));

    // R4: at most one terminate position matches
    p_term_unique_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(term_hit));

    // R8: reset loads the all-idle control block
    p_reset_idle_r8: assert property (@(posedge clk)
        !rst_n |=> (tx_block == IDLE_BLOCK));

endmodule

// File: tb/tx66_enc_tb_top.sv
// Bench for tx66_enc: table walk of block shapes, then directed reset,
// latency and padding checks.
module tx66_enc_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] tx_bytes = 64'h0707070707070707;
    logic [7:0]  tx_is_ctrl = 8'hFF;
    logic [65:0] tx_block;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [65:0] IDLE_BLK = {56'h0, 8'h1E, 2'b10};
    localparam logic [7:0] TT [8] = '{8'h87, 8'h99, 8'hAA, 8'hB4,
                                     8'hCC, 8'hD2, 8'hE1, 8'hFF};

    // {control flags, lane bytes, expected type (00 = data block)}
    localparam int NV = 21;
    localparam logic [79:0] VEC [NV] = '{
        {8'h00, 64'h8877665544332211, 8'h00},  // R1 data
        {8'hFF, 64'h0707070707070707, 8'h1E},  // R2 idle
        {8'hFF, 64'hFE07FE0707FE0707, 8'h1E},  // R2 idle/error mix
        {8'h01, 64'h88776655443322FB, 8'h78},  // R3 start
        {8'hFF, 64'h07070707070707FD, 8'h87},  // R4 k0
        {8'hFE, 64'h070707070707FD11, 8'h99},  // R4 k1
        {8'hFC, 64'h0707070707FD2211, 8'hAA},  // R4 k2
        {8'hF8, 64'h07070707FD332211, 8'hB4},  // R4 k3
        {8'hF0, 64'h070707FD44332211, 8'hCC},  // R4 k4
        {8'hE0, 64'h0707FD5544332211, 8'hD2},  // R4 k5
        {8'hC0, 64'h07FD665544332211, 8'hE1},  // R4 k6
        {8'h80, 64'hFD77665544332211, 8'hFF},  // R4 k7
        {8'hF8, 64'h07FE07FEFD332211, 8'hB4},  // R4 k3 with error codes
        {8'h18, 64'h8877660707332211, 8'h1E},  // R6 gap in flags
        {8'hFF, 64'h07070707079C0707, 8'h1E},  // R6 unknown char
        {8'h10, 64'h887766FB44332211, 8'h1E},  // R6 start in lane 4
        {8'h01, 64'h8877665544332207, 8'h1E},  // R6 lane 0 idle only
        {8'h04, 64'h8877665544FD2211, 8'h1E},  // R6 data after terminate
        {8'hFC, 64'h0707FB0707FD2211, 8'h1E},  // R6 start after terminate
        {8'hFF, 64'h07070707070707FB, 8'h1E},  // R6 start with all control
        {8'hFF, 64'h070707FD070707FD, 8'h1E}   // R6 two terminates
    };

    tx66_enc dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_bytes   (tx_bytes),
        .tx_is_ctrl (tx_is_ctrl),
        .tx_block   (tx_block)
    );

    always #2 clk = ~clk;

    // Expected block written from the requirement text.
    function automatic logic [65:0] model(input logic [7:0] c, input logic [63:0] d);
        logic [63:0] p;
        int k;
        logic ok;
        p = '0;
        if (c == 8'h00) return {d, 2'b01};
        if (c == 8'h01 && d[7:0] == 8'hFB) return {d[63:8], 8'h78, 2'b10};
        k = 0;
        while (k < 8 && !c[k]) k++;
        ok = (c == (8'hFF << k)) && (d[8*k +: 8] == 8'hFD);
        for (int j = k + 1; j < 8; j++)
            ok = ok && (d[8*j +: 8] == 8'h07 || d[8*j +: 8] == 8'hFE);
        if (ok) begin
            p[7:0] = TT[k];
            for (int j = 0; j < k; j++) p[8+8*j +: 8] = d[8*j +: 8];
            for (int j = k + 1; j < 8; j++)
                p[8+7*j +: 7] = (d[8*j +: 8] == 8'hFE) ? 7'h1E : 7'h00;
            return {p, 2'b10};
        end
        ok = (c == 8'hFF);
        for (int j = 0; j < 8; j++)
            ok = ok && (d[8*j +: 8] == 8'h07 || d[8*j +: 8] == 8'hFE);
        p[7:0] = 8'h1E;
        for (int j = 0; j < 8; j++)
            p[8+7*j +: 7] = !ok ? 7'h1E : ((d[8*j +: 8] == 8'hFE) ? 7'h1E : 7'h00);
        return {p, 2'b10};
    endfunction

    task automatic chk(input string req, input logic [65:0] act, input logic [65:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        string tag;
        logic [7:0] c, ty;
        logic [63:0] d;

        // R8: reset state
        repeat (2) @(negedge clk);
        chk("R8 reset state", tx_block, IDLE_BLK);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            c  = VEC[i][79:72];
            d  = VEC[i][71:8];
            ty = VEC[i][7:0];
            if (i == 0)       tag = "R1";
            else if (i < 3)   tag = "R2";
            else if (i == 3)  tag = "R3";
            else if (i < 13)  tag = "R4";
            else              tag = "R6";
            tx_is_ctrl = c;
            tx_bytes   = d;
            @(negedge clk);
            if (ty == 8'h00)
                chk({tag, " header"}, {64'h0, tx_block[1:0]}, {64'h0, 2'b01});
            else
                chk({tag, " header/type"}, {56'h0, tx_block[9:0]}, {56'h0, ty, 2'b10});
            chk({tag, " block"}, tx_block, model(c, d));
        end

        // R5: padding of lane-0 and lane-5 terminates is zero
        tx_is_ctrl = 8'hFF; tx_bytes = 64'hFEFEFEFEFEFEFEFD;
        @(negedge clk);
        chk("R5 pad k0", {59'h0, tx_block[16:10]}, 66'h0);
        chk("R5 codes k0", tx_block, {{7{7'h1E}}, 7'h00, 8'h87, 2'b10});
        tx_is_ctrl = 8'hE0; tx_bytes = 64'hFEFEFD5544332211;
        @(negedge clk);
        chk("R5 pad k5", {64'h0, tx_block[51:50]}, 66'h0);

        // R7: output holds until the next edge, then updates
        tx_is_ctrl = 8'hFF; tx_bytes = 64'h0707070707070707;
        @(negedge clk);
        tx_is_ctrl = 8'h00; tx_bytes = 64'hA1B2C3D4E5F60718;
        #1;
        chk("R7 holds before edge", tx_block, IDLE_BLK);
        @(negedge clk);
        chk("R7 after one edge", tx_block, {64'hA1B2C3D4E5F60718, 2'b01});

        // R8: reset during traffic overrides the inputs
        rst_n = 1'b0;
        tx_is_ctrl = 8'h00; tx_bytes = 64'h0123456789ABCDEF;
        @(negedge clk);
        chk("R8 reset mid-run", tx_block, IDLE_BLK);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset release", tx_block, {64'h0123456789ABCDEF, 2'b01});

        finish_run();
    end

endmodule